// File: doc/BRIEF.md
# Shared-Pin Bidirectional I/O Port

This block is an eight-pin general-purpose I/O port for a small microcontroller. Software reaches it through a strobed register interface. One select line chooses between two registers. The output latch holds the value that pins should drive. The direction register decides, pin by pin, whether the port drives the pad or leaves it floating. Each pin has a pad interface with three signals: a driven value, a drive enable and the level seen on the pin.

An on-chip peripheral can claim any pin by raising its own enable for that pin. The peripheral's value then reaches the pad whatever the direction bit holds. The peripheral also receives every pin level continuously through an input tap. A data-register read never returns the latch. It returns the pin level, captured through one flop, so software always sees what is actually on the wire.

Reset forces every pin to a floating input. The output latch keeps its contents across reset. Software therefore loads the latch first and only then turns on direction bits, so that no stale or unknown value is driven.

Top module: `gsp_port`

## Requirements
- R1: With direction bit 1 and peripheral enable 0, a pin has pad_oe 1 and pad_out equal to the matching output-latch bit.
- R2: With direction bit 0 and peripheral enable 0, a pin has pad_oe 0 and pad_out 0. No unknown value reaches pad_out, even when the latch has never been written.
- R3: A data-register write (reg_sel 0) updates the output latch whatever the direction bits hold. On an input pin the new value is kept and appears on pad_out once the direction bit is set.
- R4: A data-register read returns, for every bit, the pad_in level captured at the previous rising clock edge. It never returns the latch contents.
- R5: With peripheral enable 1, a pin has pad_oe 1 and pad_out equal to per_out, whatever its direction bit holds. A data read then returns that driven level.
- R6: per_in equals pad_in at all times, for every pin, in every mode.
- R7: Reset (rst_n low, asynchronous) clears all direction bits to 0, so every pin floats.
- R8: Reset leaves the output latch unchanged.
- R9: reg_sel 0 selects the data register and reg_sel 1 selects the direction register. A write strobed in one cycle takes effect at that rising edge. Reading the direction register returns its contents. rd_data is 0 while reg_rd is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 1 | 0 selects the data register, 1 selects the direction register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, 0 when no read is strobed |
| pad_out | output | 8 | Value driven to each pad |
| pad_oe | output | 8 | Per-pad drive enable |
| pad_in | input | 8 | Level observed at each pad |
| per_oe | input | 8 | Peripheral claim of each pin |
| per_out | input | 8 | Peripheral output value per pin |
| per_in | output | 8 | Continuous pin level to the peripheral |

## Verification
A data-register write can land while a peripheral owns the same pins. In that cycle the pad must keep showing the peripheral value, yet the latch must still take the new write. The bench provokes this by writing the latch with all direction bits set while the peripheral claims every pin. It first checks that pad_out still equals per_out. It then drops the peripheral enables and checks that the freshly written latch value appears at once. A second overlap occurs when the pin level changes in the same cycle as a read. That read must return the previous sample, and the bench checks the old and new values on either side of the capturing edge.

// File: rtl/gsp_pkg.sv
package gsp_pkg;
    localparam int unsigned GSP_DEF_WIDTH = 8;

    typedef enum logic {
        SEL_DATA = 1'b0,
        SEL_DIR  = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/gsp_regs.sv
module gsp_regs #(
    parameter int unsigned WIDTH = gsp_pkg::GSP_DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] dir_o,
    output logic [WIDTH-1:0] latch_o,
    output logic [WIDTH-1:0] sample_o
);
    localparam logic [WIDTH-1:0] ALL_INPUT = '0;

    typedef struct packed {
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] sample;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic [WIDTH-1:0] latch_d, latch_q;
    gsp_pkg::reg_sel_e sel;

    assign sel = gsp_pkg::reg_sel_e'(reg_sel);

    always_comb begin
        ctl_d        = ctl_q;
        latch_d      = latch_q;
        ctl_d.sample = pad_in;
        if (reg_wr) begin
            if (sel == gsp_pkg::SEL_DIR) ctl_d.dir = wr_data;
            else                         latch_d   = wr_data;
        end
    end

    // direction and sample flop are reset; the latch deliberately is not
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.dir    <= ALL_INPUT;
            ctl_q.sample <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_ff @(posedge clk) begin
        latch_q <= latch_d;
    end

    assign dir_o    = ctl_q.dir;
    assign latch_o  = latch_q;
    assign sample_o = ctl_q.sample;

    always @(posedge clk) begin
        if (!rst_n) assert_dir_cleared_R7: assert (ctl_q.dir == ALL_INPUT);
    end

    assert_latch_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_sel) |=> (latch_q == $past(wr_data)));

    assert_dir_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel) |=> (ctl_q.dir == $past(wr_data)));

    assert_sample_stage_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ctl_q.sample == $past(pad_in)));
endmodule

// File: rtl/gsp_pinmux.sv
module gsp_pinmux #(
    parameter int unsigned WIDTH = gsp_pkg::GSP_DEF_WIDTH
) (
    input  logic [WIDTH-1:0] dir,
    input  logic [WIDTH-1:0] latch,
    input  logic [WIDTH-1:0] per_oe,
    input  logic [WIDTH-1:0] per_out,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        // peripheral claim wins; an undriven pin outputs a clean 0
        assign pad_oe[i]  = per_oe[i] | dir[i];
        assign pad_out[i] = per_oe[i] ? per_out[i]
                          : (dir[i] ? latch[i] : 1'b0);
    end
endmodule

// File: rtl/gsp_readback.sv
module gsp_readback #(
    parameter int unsigned WIDTH = gsp_pkg::GSP_DEF_WIDTH
) (
    input  logic             reg_rd,
    input  logic             reg_sel,
    input  logic [WIDTH-1:0] dir,
    input  logic [WIDTH-1:0] sample,
    output logic [WIDTH-1:0] rd_data
);
    always_comb begin
        rd_data = '0;
        if (reg_rd) begin
            if (gsp_pkg::reg_sel_e'(reg_sel) == gsp_pkg::SEL_DIR) rd_data = dir;
            else                                                  rd_data = sample;
        end
    end
endmodule

// File: rtl/gsp_port.sv
module gsp_port #(
    parameter int unsigned WIDTH = gsp_pkg::GSP_DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic             reg_sel,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_data,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    input  logic [WIDTH-1:0] pad_in,
    input  logic [WIDTH-1:0] per_oe,
    input  logic [WIDTH-1:0] per_out,
    output logic [WIDTH-1:0] per_in
);
    logic [WIDTH-1:0] dir_q, latch_q, sample_q;

    gsp_regs #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .wr_data(wr_data), .pad_in(pad_in),
        .dir_o(dir_q), .latch_o(latch_q), .sample_o(sample_q)
    );

    gsp_pinmux #(.WIDTH(WIDTH)) u_pinmux (
        .dir(dir_q), .latch(latch_q), .per_oe(per_oe), .per_out(per_out),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    gsp_readback #(.WIDTH(WIDTH)) u_readback (
        .reg_rd(reg_rd), .reg_sel(reg_sel), .dir(dir_q), .sample(sample_q),
        .rd_data(rd_data)
    );

    // the input tap follows the pad with no storage
    assign per_in = pad_in;

    assert_quiet_pad_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((~dir_q & ~per_oe & (pad_out | pad_oe)) == '0));

    assert_per_claim_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((per_oe & ~pad_oe) == '0));

    assert_port_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((dir_q & ~per_oe & (pad_out ^ latch_q)) == '0));
endmodule

// File: tb/gsp_port_test.sv
module gsp_port_test;
    localparam int W = 8;
    localparam int NVEC = 8;
    // {dir, latch, per_oe, per_out, ext, exp_oe, exp_out, exp_rd}
    localparam logic [63:0] VEC [NVEC] = '{
        {8'hFF, 8'h5A, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h5A, 8'h5A},
        {8'h00, 8'h5A, 8'h00, 8'h00, 8'hC3, 8'h00, 8'h00, 8'hC3},
        {8'hF0, 8'h3C, 8'h00, 8'h00, 8'h0F, 8'hF0, 8'h30, 8'h3F},
        {8'h00, 8'hFF, 8'h0F, 8'h05, 8'hA0, 8'h0F, 8'h05, 8'hA5},
        {8'hFF, 8'h00, 8'h81, 8'h81, 8'h00, 8'hFF, 8'h81, 8'h81},
        {8'h0F, 8'hAA, 8'hF0, 8'h50, 8'h00, 8'hFF, 8'h5A, 8'h5A},
        {8'h33, 8'hCC, 8'h44, 8'h00, 8'hFF, 8'h77, 8'h00, 8'h88},
        {8'h00, 8'h00, 8'hFF, 8'h96, 8'h00, 8'hFF, 8'h96, 8'h96}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 1'b0, reg_rd = 1'b0, reg_sel = 1'b0;
    logic [W-1:0] wr_data = '0, per_oe = '0, per_out = '0, ext = '0;
    logic [W-1:0] rd_data, pad_out, pad_oe, pad_in, per_in;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    // pad model: driven pins loop back, floating pins take the external level
    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

    gsp_port #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_sel(reg_sel), .wr_data(wr_data), .rd_data(rd_data),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_in(pad_in),
        .per_oe(per_oe), .per_out(per_out), .per_in(per_in)
    );

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic sel, logic [W-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; wr_data = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic sel, output logic [W-1:0] d);
        reg_sel = sel; reg_rd = 1'b1;
        #1 d = rd_data;
        reg_rd = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk); @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v;
        // reset state, latch never written
        repeat (3) @(negedge clk);
        check("R7 reset oe", pad_oe, 8'h00);
        check("R2 no X on pad in reset", pad_out, 8'h00);
        rd(1'b1, v); check("R7 dir read in reset", v, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 no X after reset", pad_out, 8'h00);
        check("R9 rd_data idle", rd_data, 8'h00);

        // vector table
        for (int k = 0; k < NVEC; k++) begin
            per_oe = '0;
            wr(1'b0, VEC[k][63-8:48]);
            wr(1'b1, VEC[k][63:56]);
            per_oe = VEC[k][47:40]; per_out = VEC[k][39:32]; ext = VEC[k][31:24];
            settle();
            check("R1 R5 vec pad_oe", pad_oe, VEC[k][23:16]);
            check("R1 R2 R5 vec pad_out", pad_out, VEC[k][15:8]);
            check("R6 vec per_in", per_in, VEC[k][7:0]);
            rd(1'b0, v); check("R4 R5 vec data read", v, VEC[k][7:0]);
            rd(1'b1, v); check("R9 vec dir read", v, VEC[k][63:56]);
        end

        // R3: latch write on input pins held, then driven
        per_oe = '0; ext = 8'h00;
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h69);
        check("R3 held not driven oe", pad_oe, 8'h00);
        check("R3 held not driven out", pad_out, 8'h00);
        wr(1'b1, 8'hFF);
        check("R3 latch appears", pad_out, 8'h69);

        // R4: read returns pin, not latch
        wr(1'b1, 8'h00);
        wr(1'b0, 8'hFF);
        ext = 8'h00; settle();
        rd(1'b0, v); check("R4 read ignores latch", v, 8'h00);

        // R4: one-stage capture, change and read in the same cycle
        ext = 8'h11; settle();
        @(negedge clk); ext = 8'h22;
        rd(1'b0, v); check("R4 old sample before edge", v, 8'h11);
        check("R6 tap immediate", per_in, 8'h22);
        @(negedge clk);
        rd(1'b0, v); check("R4 new sample after edge", v, 8'h22);

        // overlap: latch write while peripheral owns the pins
        wr(1'b1, 8'hFF);
        per_oe = 8'hFF; per_out = 8'h0F;
        wr(1'b0, 8'hF0);
        check("R5 peripheral keeps pad", pad_out, 8'h0F);
        per_oe = 8'h00; #1;
        check("R3 written latch after release", pad_out, 8'hF0);

        // R8: latch survives reset, R7 direction cleared
        wr(1'b0, 8'hA5);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R7 reset floats pins", pad_oe, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        rd(1'b1, v); check("R7 dir zero after reset", v, 8'h00);
        wr(1'b1, 8'hFF);
        check("R8 latch kept over reset", pad_out, 8'hA5);
        check("R9 rd_data zero without strobe", rd_data, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule